// File: doc/BRIEF.md
# Lane-Preserving Warp Regrouper

This block takes the branch-outcome masks of a group of warps that have all reached the same divergent branch, and forms new warps so that the threads taking the branch are packed into as few warps as possible. A thread's registers sit in the SIMD lane it runs on, so a thread may change warps but never lanes. Two taken threads that share a lane index therefore always land in different formed warps. Packing is done column by column: each lane's taken threads are stacked into the lowest-numbered formed warps, in increasing order of source warp index.

A caller presents `NUM_WARPS` masks of `LANES` bits on `warpMasks`, where bit `w*LANES + j` is 1 when thread j of source warp w takes the branch, and pulses `start`. The block captures the masks, takes one cycle per source warp, then pulses `done`. From that cycle on, it shows the formed warp masks, the source warp for every occupied slot, and the number of non-empty formed warps. These results hold until the next accepted start. Moving registers and issuing the formed warps are the caller's job.

Top module: `warp_regroup`

## Requirements
- R1: After reset, `done` is 0, and `formedMasks`, `srcValid`, `srcIdx` and `numActive` are all zero.
- R2: A start accepted at clock edge E makes `done` high for exactly one cycle, right after edge E+NUM_WARPS. Before and after that cycle it is low.
- R3: Bit `m*LANES + j` of `formedMasks` is set only if some source warp has bit j set. The slot's `srcIdx` field, bits `(m*LANES+j)*IDX_W` upward, holds that source warp's index, so a thread only ever moves within its lane j.
- R4: For each lane j, formed warp m holds the (m+1)-th taken thread of lane j, counting source warps from index 0 upward. The occupied formed warps of a lane are therefore always 0 up to its count minus 1.
- R5: Each lane's count of taken threads is the same across the input and the formed warps, and no slot holds more than one thread.
- R6: `numActive` equals the largest per-lane count of taken threads over all lanes. For example, with lane 0 set in warps 0 and 1 and lane 1 set only in warp 2, `numActive` is 2 and formed warp 1 holds only lane 0.
- R7: `srcValid` bit `m*LANES+j` is 1 exactly where a thread occupies the slot. The `srcIdx` field of an unoccupied slot reads 0.
- R8: A `start` pulse while a regroup is in progress is ignored. Neither the result nor the timing of `done` changes.
- R9: After `done`, all outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a regroup of `warpMasks` when idle |
| warpMasks | input | NUM_WARPS*LANES | Branch-taken masks, source warp w in bits w*LANES upward |
| done | output | 1 | One-cycle pulse when results are ready |
| formedMasks | output | NUM_WARPS*LANES | Taken masks of the formed warps |
| srcValid | output | NUM_WARPS*LANES | Slot-occupied flags |
| srcIdx | output | NUM_WARPS*LANES*IDX_W | Source warp index per formed slot |
| numActive | output | CNT_W | Number of non-empty formed warps |

## Verification
The lanes are given column patterns so that every one of the sixteen possible four-warp columns shows up in every trial batch. This tells apart compaction order, lane preservation and the maximum count in a single run. Pseudo-random masks add mixed columns. All-zero and all-one inputs bound the count at 0 and NUM_WARPS. The three-warp case where one warp's lone taken thread must merge with another separates lane-restricted packing from free repacking. A start pulse injected mid-run, together with checks after `done`, shows that a busy block ignores new requests and keeps its result.

// File: rtl/warp_regroup_pkg.sv
package warp_regroup_pkg;
  localparam int STEP_W = 8;

  typedef struct packed {
    logic              clear;
    logic              step;
    logic [STEP_W-1:0] idx;
  } regroupStrobe_t;
endpackage

// File: rtl/warp_regroup_ctrl.sv
module warp_regroup_ctrl
  import warp_regroup_pkg::*;
#(
  parameter int NUM_WARPS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output regroupStrobe_t strb,
  output logic           busy,
  output logic           done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WARPS - 1);

  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        stepCnt <= '0;
        if (start) busy <= 1'b1;
      end else if (stepCnt == LAST_STEP) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.clear = !busy && start;
    strb.step  = busy;
    strb.idx   = stepCnt;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && !busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (stepCnt != LAST_STEP) |=> busy && (stepCnt == $past(stepCnt) + 1'b1));
endmodule

// File: rtl/warp_regroup_dp.sv
module warp_regroup_dp
  import warp_regroup_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int LANES     = 32,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  regroupStrobe_t                 strb,
  input  logic [NUM_WARPS*LANES-1:0]     warpMasks,
  output logic [NUM_WARPS*LANES-1:0]     formedFlat,
  output logic [NUM_WARPS*LANES*IDX_W-1:0] srcFlat,
  output logic [CNT_W-1:0]               numActive
);
  logic [NUM_WARPS-1:0][LANES-1:0]            maskReg;
  logic [NUM_WARPS-1:0][LANES-1:0]            formed;
  logic [NUM_WARPS-1:0][LANES-1:0][IDX_W-1:0] srcReg;
  logic [LANES-1:0][CNT_W-1:0]                laneCnt;
  logic [LANES-1:0]                           curBits;

  always_comb begin
    curBits = '0;
    for (int k = 0; k < NUM_WARPS; k++)
      if (strb.idx == STEP_W'(k)) curBits = maskReg[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '0;
      formed  <= '0;
      srcReg  <= '0;
      laneCnt <= '0;
    end else if (strb.clear) begin
      maskReg <= warpMasks;
      formed  <= '0;
      srcReg  <= '0;
      laneCnt <= '0;
    end else if (strb.step) begin
      for (int j = 0; j < LANES; j++) begin
        if (curBits[j]) begin
          for (int m = 0; m < NUM_WARPS; m++) begin
            if (laneCnt[j] == CNT_W'(m)) begin
              formed[m][j] <= 1'b1;
              srcReg[m][j] <= strb.idx[IDX_W-1:0];
            end
          end
          laneCnt[j] <= laneCnt[j] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    numActive = '0;
    for (int j = 0; j < LANES; j++)
      if (laneCnt[j] > numActive) numActive = laneCnt[j];
  end

  assign formedFlat = formed;
  assign srcFlat    = srcReg;

  genvar gj, gm;
  generate
    for (gj = 0; gj < LANES; gj++) begin : g_laneChk
      assert_lane_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        laneCnt[gj] <= CNT_W'(NUM_WARPS));
    end
    for (gm = 1; gm < NUM_WARPS; gm++) begin : g_compactChk
      assert_compact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (formed[gm] & ~formed[gm-1]) == '0);
    end
  endgenerate
endmodule

// File: rtl/warp_regroup.sv
module warp_regroup
  import warp_regroup_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int LANES     = 32,
  localparam int IDX_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int CNT_W    = $clog2(NUM_WARPS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [NUM_WARPS*LANES-1:0]       warpMasks,
  output logic                             done,
  output logic [NUM_WARPS*LANES-1:0]       formedMasks,
  output logic [NUM_WARPS*LANES-1:0]       srcValid,
  output logic [NUM_WARPS*LANES*IDX_W-1:0] srcIdx,
  output logic [CNT_W-1:0]                 numActive
);
  regroupStrobe_t strb;
  logic           busy;

  warp_regroup_ctrl #(.NUM_WARPS(NUM_WARPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strb(strb), .busy(busy), .done(done)
  );

  warp_regroup_dp #(
    .NUM_WARPS(NUM_WARPS), .LANES(LANES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .warpMasks(warpMasks),
    .formedFlat(formedMasks), .srcFlat(srcIdx), .numActive(numActive)
  );

  assign srcValid = formedMasks;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(formedMasks) && $stable(srcIdx) && $stable(numActive));

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    numActive <= CNT_W'(NUM_WARPS));
endmodule

// File: tb/warp_regroup_bench.sv
module warp_regroup_bench;
  localparam int  K      = 4;
  localparam int  W      = 32;
  localparam int  IW     = 2;
  localparam int  CW     = 3;
  localparam time CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [K*W-1:0]     warpMasks = '0;
  logic               done;
  logic [K*W-1:0]     formedMasks, srcValid;
  logic [K*W*IW-1:0]  srcIdx;
  logic [CW-1:0]      numActive;

  int checks = 0;
  int fails  = 0;
  logic [K*W-1:0]    expMask;
  logic [K*W*IW-1:0] expSrc;
  int                expNum;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_regroup #(.NUM_WARPS(K), .LANES(W)) u_warp_regroup (
    .clk(clk), .rst_n(rst_n), .start(start), .warpMasks(warpMasks),
    .done(done), .formedMasks(formedMasks), .srcValid(srcValid),
    .srcIdx(srcIdx), .numActive(numActive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected result by per-lane ranking of taken threads
  task automatic computeExp(input logic [K*W-1:0] m);
    expMask = '0; expSrc = '0; expNum = 0;
    for (int j = 0; j < W; j++) begin
      int rank = 0;
      for (int k = 0; k < K; k++) begin
        if (m[k*W+j]) begin
          expMask[rank*W+j] = 1'b1;
          expSrc[(rank*W+j)*IW +: IW] = IW'(k);
          rank++;
        end
      end
      if (rank > expNum) expNum = rank;
    end
  endtask

  task automatic runTrial(input logic [K*W-1:0] m, input bit poke);
    int doneErr = 0;
    computeExp(m);
    @(negedge clk); warpMasks = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 2; c <= K + 2; c++) begin
      if (poke && c == 3) begin start = 1'b1; warpMasks = ~m; end
      @(negedge clk);
      start = 1'b0;
      if (done !== (c == K + 1)) doneErr++;
      if (c == K + 1) begin
        check(formedMasks === expMask, "R4", "formed masks", formedMasks, expMask);
        check(srcIdx === expSrc, "R3", "source index", srcIdx, expSrc);
        check(srcValid === expMask, "R7", "slot valid", srcValid, expMask);
        check(numActive === CW'(expNum), "R6", "active count", numActive, expNum);
        check($countones(formedMasks) == $countones(m), "R5", "thread total",
              $countones(formedMasks), $countones(m));
      end
    end
    check(doneErr == 0, poke ? "R8" : "R2", "done timing", doneErr, 0);
    @(negedge clk); @(negedge clk);
    check(formedMasks === expMask && srcIdx === expSrc && numActive === CW'(expNum),
          "R9", "hold after done", formedMasks, expMask);
  endtask

  initial begin
    logic [K*W-1:0] m;
    logic [31:0] lfsr = 32'h1ACE_5EED;
    #(CLK_PERIOD * 2.5);
    check(done === 1'b0 && formedMasks === '0 && srcValid === '0 &&
          srcIdx === '0 && numActive === '0, "R1", "reset state", formedMasks, 0);
    rst_n = 1'b1;

    // column sweep: every 4-bit lane column appears in each trial batch
    for (int t = 0; t < 16; t++) begin
      m = '0;
      for (int j = 0; j < W; j++) begin
        int col = (t * 7 + j * 3 + j / 16) % 16;
        for (int k = 0; k < K; k++) m[k*W+j] = col[k];
      end
      runTrial(m, 1'b0);
    end
    // pseudo-random masks
    for (int t = 0; t < 24; t++) begin
      for (int w = 0; w < K; w++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        m[w*W +: W] = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      end
      runTrial(m, t % 4 == 0);
    end
    runTrial('0, 1'b0);
    runTrial('1, 1'b0);
    // R6 example: lane0 in warps 0 and 1, lane1 in warp 2, lanes 30/31 in 0/1
    m = '0;
    m[0*W+0] = 1'b1; m[0*W+30] = 1'b1;
    m[1*W+0] = 1'b1; m[1*W+31] = 1'b1;
    m[2*W+1] = 1'b1;
    runTrial(m, 1'b0);
    check(numActive === 3'd2 && formedMasks[1*W +: W] === 32'h1 &&
          formedMasks[2*W +: W] === '0, "R6", "merge example", formedMasks, 0);
    runTrial(m, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule